// File: doc/BRIEF.md
# Frame Process Sequencer

This block launches and tracks compression or expansion passes over a video stream, one pass per frame (or per field when the video is interlaced). A host sets the operating mode and issues commands through a small asynchronous register bus: chip select, write strobe, read strobe, a two-bit address and a data bus. The bus strobes, the vertical sync input and the start and stop pins are asynchronous. Each one passes through a two-stage synchronizer and is then reduced to a single-cycle rising-edge event.

A start request is held pending until the next vertical sync edge, and the pass begins on that edge. The busy output stays high until the controlled datapath, which is modelled here only by its one-cycle `pass_done` input, reports that the pass has finished. In single-frame mode the unit then goes idle until the host starts it again. In sequential mode it re-arms and launches a new pass at every following sync edge, until it is stopped or disabled.

The controller is built around three states:
- IDLE: nothing pending.
- ARMED: waiting for a sync edge.
- RUN: a pass is in progress.

It has six transitions:
- IDLE→ARMED: an enabled start request.
- ARMED→RUN: a sync edge (launch).
- ARMED→IDLE: a stop request, or enable cleared.
- RUN→IDLE: done in single-frame mode, or after a stop.
- RUN→ARMED: done in sequential mode.
- RUN→RUN: done and a sync edge in the same cycle in sequential mode (immediate relaunch).

Top module: `frame_pass_seq`

## Requirements
- R1: After reset the unit is idle: `busy_o`, `launch_o`, `eop_o` and `compress_o` are 0, and the mode and status registers read 0.
- R2: Address 0 is the mode register. Bit 0 is enable, bit 1 is sequential (1) or single-frame (0), and bit 2 is compress (1) or expand (0). Bits above 2 always read 0. `compress_o` follows bit 2.
- R3: A start request arms the unit, but only while enable is 1. A start request is either a write of 1 to bit 0 of address 2, or a rising edge on `start_in`. The pass then begins at the next rising edge of `vsync_in`: `launch_o` pulses for one cycle, in the same cycle in which `busy_o` rises. While the unit is armed without a sync edge, `busy_o` stays 0. A start request with enable at 0 is ignored.
- R4: `busy_o` stays 1 until `pass_done` is seen. `busy_o` falls in the cycle in which `eop_o` pulses.
- R5: In single-frame mode, after `pass_done` the unit goes idle. Later sync edges launch nothing.
- R6: In sequential mode with enable at 1, after `pass_done` the unit returns to the armed state. The next sync edge launches a new pass without any host action.
- R7: A stop request is a rising edge on `stop_in` or a write of 1 to bit 1 of address 2. Clearing enable has the same effect. A stop during a pass lets that pass run to `pass_done`, after which the unit goes idle. A stop while armed cancels the pending start at once.
- R8: A sync edge that arrives while a pass is busy (with no `pass_done` in the same cycle) launches nothing. It sets the sticky overrun bit instead.
- R9: Address 1 is read-only status. Bit 0 is busy, bit 1 is pass-complete (sticky), bit 2 is overrun (sticky) and bit 3 is armed. A read returns the value from before the read, and the read clears bits 1 and 2. Writes to address 1 change nothing.
- R10: Address 2 reads 0. Address 3 reads 0 and ignores writes. A write to any address other than 0 leaves the mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select, asynchronous |
| host_wr | input | 1 | Host write strobe, asynchronous, acts on its rising edge while selected |
| host_rd | input | 1 | Host read strobe, asynchronous, acts on its rising edge while selected |
| host_addr | input | ADDR_W | Register address, held stable around the strobe |
| host_wdata | input | DATA_W | Write data, held stable around the strobe |
| host_rdata | output | DATA_W | Data captured by the last read, held until the next read |
| vsync_in | input | 1 | Frame/field boundary, rising edge significant |
| start_in | input | 1 | Start pin, rising edge significant |
| stop_in | input | 1 | Stop pin, rising edge significant |
| pass_done | input | 1 | One-cycle pulse from the datapath: current pass finished |
| busy_o | output | 1 | A pass is in progress |
| compress_o | output | 1 | Selected pass type, 1 = compression, 0 = expansion |
| launch_o | output | 1 | One-cycle pulse when a pass begins |
| eop_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
Assertions check on every cycle the relationships that hold within one or two cycles:
- a launch coincides with busy rising;
- busy holds until done, and falls only together with the end-of-pass pulse;
- an armed unit without a sync edge does not go busy;
- a busy sync edge raises the overrun flag and its sticky bit;
- single-frame completion always lands in idle;
- the mode register stays stable on writes to other addresses.

Only the bench scenarios can show the longer sequences. These are the sequential re-arm and relaunch across several frames, a stop that lets the running pass finish and then blocks later frames, the cancelling of a pending start, and the clear-on-read behaviour of the status bits as seen across successive host reads.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } fps_state_e;

    // register addresses
    localparam int REG_MODE = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CMD  = 2;

    // mode register fields
    localparam int MODE_BITS    = 3;
    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_SEQ_BIT = 1;
    localparam int MODE_CMP_BIT = 2;

    // command register fields
    localparam int CMD_START_BIT = 0;
    localparam int CMD_STOP_BIT  = 1;

    // number of synchronized event lines
    localparam int EVT_LINES = 5;

endpackage

// File: rtl/fps_edge_sync.sv
module fps_edge_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[STAGES-1];
    end

    assign rise_o = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fps_regs.sv
module fps_regs
    import fps_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              armed,
    input  logic              eop_evt,
    input  logic              ovr_evt,
    output logic [DATA_W-1:0] rdata,
    output logic              mode_en,
    output logic              mode_seq,
    output logic              mode_cmp,
    output logic              cmd_start,
    output logic              cmd_stop
);

    localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'((1 << MODE_BITS) - 1);
    localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(REG_CMD);

    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_stk_q;
    logic              ovr_stk_q;
    logic              stat_clr;
    logic [DATA_W-1:0] stat_word;

    assign stat_clr  = rd_evt && (addr == A_STAT);
    assign stat_word = DATA_W'({armed, ovr_stk_q, done_stk_q, busy});

    assign cmd_start = wr_evt && (addr == A_CMD) && wdata[CMD_START_BIT];
    assign cmd_stop  = wr_evt && (addr == A_CMD) && wdata[CMD_STOP_BIT];

    assign mode_en  = mode_q[MODE_EN_BIT];
    assign mode_seq = mode_q[MODE_SEQ_BIT];
    assign mode_cmp = mode_q[MODE_CMP_BIT];
    assign rdata    = rdata_q;

    // mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_evt && (addr == A_MODE)) begin
            mode_q <= wdata & MODE_MASK;
        end
    end

    // sticky status: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_stk_q <= 1'b0;
            ovr_stk_q  <= 1'b0;
        end else begin
            done_stk_q <= (done_stk_q && !stat_clr) || eop_evt;
            ovr_stk_q  <= (ovr_stk_q  && !stat_clr) || ovr_evt;
        end
    end

    // read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_evt) begin
            unique case (addr)
                A_MODE:  rdata_q <= mode_q;
                A_STAT:  rdata_q <= stat_word;
                default: rdata_q <= '0;
            endcase
        end
    end

    // R8: an overrun event is always recorded
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_stk_q);

    // R9: a status read without a new completion clears the complete bit
    p_clear_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !eop_evt) |=> !done_stk_q);

    // R10: writes elsewhere leave the mode untouched
    p_mode_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_evt && (addr == A_MODE))) |=> $stable(mode_q));

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic mode_seq,
    input  logic start_req,
    input  logic stop_req,
    input  logic vs_edge,
    input  logic done,
    output logic busy_o,
    output logic armed_o,
    output logic launch_o,
    output logic eop_o,
    output logic ovr_o
);

    fps_state_e state_q, state_d;
    logic       stop_pend_q, stop_pend_d;
    logic       launch_d, eop_d, ovr_d;
    logic       launch_q, eop_q, ovr_q;
    logic       keep_going;

    assign keep_going = mode_seq && mode_en && !stop_pend_q && !stop_req;

    // next state and event decisions
    always_comb begin
        state_d     = state_q;
        stop_pend_d = 1'b0;
        launch_d    = 1'b0;
        eop_d       = 1'b0;
        ovr_d       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req && mode_en) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_req || !mode_en) begin
                    state_d = ST_IDLE;
                end else if (vs_edge) begin
                    state_d  = ST_RUN;
                    launch_d = 1'b1;
                end
            end
            ST_RUN: begin
                if (done) begin
                    eop_d = 1'b1;
                    if (keep_going) begin
                        if (vs_edge) begin
                            state_d  = ST_RUN;
                            launch_d = 1'b1;
                        end else begin
                            state_d = ST_ARMED;
                        end
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    stop_pend_d = stop_pend_q || stop_req;
                    ovr_d       = vs_edge;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            stop_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            stop_pend_q <= stop_pend_d;
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_q <= 1'b0;
            eop_q    <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            launch_q <= launch_d;
            eop_q    <= eop_d;
            ovr_q    <= ovr_d;
        end
    end

    assign busy_o   = (state_q == ST_RUN);
    assign armed_o  = (state_q == ST_ARMED);
    assign launch_o = launch_q;
    assign eop_o    = eop_q;
    assign ovr_o    = ovr_q;

    // R3: every launch comes with busy
    p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> busy_o);

    // R3: busy rises only through a launch
    p_rose_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> launch_o);

    // R3: armed without a sync edge does not go busy
    p_armed_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !vs_edge) |=> !busy_o);

    // R4: a pass holds until done
    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done) |=> busy_o);

    // R4: busy falls only with the end-of-pass pulse
    p_fall_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> eop_o);

    // R5: single-frame completion returns to idle
    p_single_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done && !mode_seq) |=> (!busy_o && !armed_o));

    // R8: a sync edge during a pass flags overrun and relaunches nothing
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && vs_edge && !done) |=> (ovr_o && busy_o && !launch_o));

endmodule

// File: rtl/frame_pass_seq.sv
module frame_pass_seq
    import fps_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              vsync_in,
    input  logic              start_in,
    input  logic              stop_in,
    input  logic              pass_done,
    output logic              busy_o,
    output logic              compress_o,
    output logic              launch_o,
    output logic              eop_o
);

    logic [EVT_LINES-1:0] raw_lines;
    logic [EVT_LINES-1:0] rises;
    logic wr_evt, rd_evt, vs_edge, pin_start, pin_stop;
    logic mode_en, mode_seq, mode_cmp;
    logic cmd_start, cmd_stop;
    logic armed, ovr_evt;

    assign raw_lines = {stop_in, start_in, vsync_in,
                        host_cs & host_rd, host_cs & host_wr};

    fps_edge_sync #(
        .WIDTH  (EVT_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .rise_o   (rises)
    );

    assign wr_evt    = rises[0];
    assign rd_evt    = rises[1];
    assign vs_edge   = rises[2];
    assign pin_start = rises[3];
    assign pin_stop  = rises[4];

    fps_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .rd_evt    (rd_evt),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .busy      (busy_o),
        .armed     (armed),
        .eop_evt   (eop_o),
        .ovr_evt   (ovr_evt),
        .rdata     (host_rdata),
        .mode_en   (mode_en),
        .mode_seq  (mode_seq),
        .mode_cmp  (mode_cmp),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop)
    );

    fps_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .mode_seq  (mode_seq),
        .start_req (cmd_start | pin_start),
        .stop_req  (cmd_stop | pin_stop),
        .vs_edge   (vs_edge),
        .done      (pass_done),
        .busy_o    (busy_o),
        .armed_o   (armed),
        .launch_o  (launch_o),
        .eop_o     (eop_o),
        .ovr_o     (ovr_evt)
    );

    assign compress_o = mode_cmp;

endmodule

// File: tb/frame_pass_seq_bench.sv
`timescale 1ns/1ps
module frame_pass_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       vsync_in = 1'b0, start_in = 1'b0, stop_in = 1'b0;
    logic       pass_done = 1'b0;
    logic       busy_o, compress_o, launch_o, eop_o;

    int n_checks = 0;
    int n_fail   = 0;
    int launches = 0;
    int eops     = 0;

    always #2.5 clk = ~clk;

    frame_pass_seq u_frame_pass_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .vsync_in   (vsync_in),
        .start_in   (start_in),
        .stop_in    (stop_in),
        .pass_done  (pass_done),
        .busy_o     (busy_o),
        .compress_o (compress_o),
        .launch_o   (launch_o),
        .eop_o      (eop_o)
    );

    always @(posedge clk) begin
        if (launch_o) launches <= launches + 1;
        if (eop_o)    eops     <= eops + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs = 1'b1; host_wr = 1'b1;
        idle_cycles(4);
        host_wr = 1'b0; host_cs = 1'b0;
        idle_cycles(4);
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_cs = 1'b1; host_rd = 1'b1;
        idle_cycles(4);
        host_rd = 1'b0; host_cs = 1'b0;
        idle_cycles(4);
        d = host_rdata;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync_in = 1'b1;
        idle_cycles(4); vsync_in = 1'b0;
        idle_cycles(4);
    endtask

    task automatic pulse_start_pin();
        @(negedge clk); start_in = 1'b1;
        idle_cycles(4); start_in = 1'b0;
        idle_cycles(4);
    endtask

    task automatic pulse_stop_pin();
        @(negedge clk); stop_in = 1'b1;
        idle_cycles(4); stop_in = 1'b0;
        idle_cycles(4);
    endtask

    task automatic pulse_done();
        @(negedge clk); pass_done = 1'b1;
        @(negedge clk); pass_done = 1'b0;
        idle_cycles(2);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 busy", busy_o, 0);
        chk("R1 launch", launch_o, 0);
        chk("R1 eop", eop_o, 0);
        chk("R1 compress", compress_o, 0);
        host_read(2'd0, v); chk("R1 mode", v, 8'h00);
        host_read(2'd1, v); chk("R1 status", v, 8'h00);
    endtask

    task automatic t_mode_rw();
        logic [7:0] v;
        host_write(2'd0, 8'hFF);
        host_read(2'd0, v); chk("R2 mode masked", v, 8'h07);
        chk("R2 compress on", compress_o, 1);
        host_write(2'd0, 8'h01);
        host_read(2'd0, v); chk("R2 mode readback", v, 8'h01);
        chk("R2 compress off", compress_o, 0);
    endtask

    task automatic t_disabled_start();
        logic [7:0] v;
        int l0 = launches;
        host_write(2'd0, 8'h00);
        host_write(2'd2, 8'h01);
        host_read(2'd1, v); chk("R3 disabled no arm", v, 8'h00);
        pulse_vsync();
        chk("R3 disabled no launch", launches - l0, 0);
        chk("R3 disabled busy", busy_o, 0);
    endtask

    task automatic t_single();
        logic [7:0] v;
        int l0 = launches;
        int e0 = eops;
        host_write(2'd0, 8'h05);
        host_write(2'd2, 8'h01);
        host_read(2'd1, v); chk("R3 armed status", v, 8'h08);
        chk("R3 waits for sync", busy_o, 0);
        pulse_vsync();
        chk("R3 busy after sync", busy_o, 1);
        chk("R3 one launch", launches - l0, 1);
        idle_cycles(20);
        chk("R4 busy holds", busy_o, 1);
        pulse_done();
        chk("R4 busy cleared", busy_o, 0);
        chk("R4 one eop", eops - e0, 1);
        pulse_vsync();
        chk("R5 no relaunch", launches - l0, 1);
        chk("R5 idle", busy_o, 0);
        host_read(2'd1, v); chk("R9 complete sticky", v, 8'h02);
        host_read(2'd1, v); chk("R9 cleared on read", v, 8'h00);
    endtask

    task automatic t_sequential();
        logic [7:0] v;
        int l0 = launches;
        host_write(2'd0, 8'h03);
        pulse_start_pin();
        host_read(2'd1, v); chk("R3 pin start arms", v, 8'h08);
        pulse_vsync();
        chk("R3 pin start launch", launches - l0, 1);
        pulse_done();
        chk("R6 busy low between", busy_o, 0);
        host_read(2'd1, v); chk("R6 re-armed", v, 8'h0A);
        pulse_vsync();
        chk("R6 auto relaunch", launches - l0, 2);
        chk("R6 busy again", busy_o, 1);
        pulse_vsync();
        chk("R8 no launch when busy", launches - l0, 2);
        host_read(2'd1, v); chk("R8 overrun status", v, 8'h05);
        pulse_stop_pin();
        chk("R7 pass continues", busy_o, 1);
        pulse_done();
        chk("R7 idle after stop", busy_o, 0);
        pulse_vsync();
        chk("R7 no launch after stop", launches - l0, 2);
        host_read(2'd1, v); chk("R7 status after stop", v, 8'h02);
    endtask

    task automatic t_stop_armed();
        logic [7:0] v;
        int l0 = launches;
        host_write(2'd0, 8'h03);
        host_write(2'd2, 8'h01);
        host_read(2'd1, v); chk("R7 armed before stop", v, 8'h08);
        host_write(2'd2, 8'h02);
        host_read(2'd1, v); chk("R7 stop cancels", v, 8'h00);
        pulse_vsync();
        chk("R7 cancelled no launch", launches - l0, 0);
    endtask

    task automatic t_enable_clear();
        logic [7:0] v;
        int l0 = launches;
        host_write(2'd0, 8'h03);
        host_write(2'd2, 8'h01);
        pulse_vsync();
        chk("R7 enable run", busy_o, 1);
        host_write(2'd0, 8'h02);
        chk("R7 disable keeps pass", busy_o, 1);
        pulse_done();
        host_read(2'd1, v); chk("R7 disable goes idle", v, 8'h02);
        pulse_vsync();
        chk("R7 disabled no relaunch", launches - l0, 1);
    endtask

    task automatic t_addr_map();
        logic [7:0] v;
        host_write(2'd0, 8'h05);
        host_write(2'd1, 8'hFF);
        host_read(2'd1, v); chk("R9 status write ignored", v, 8'h00);
        host_read(2'd2, v); chk("R10 cmd reads zero", v, 8'h00);
        host_write(2'd3, 8'hFF);
        host_read(2'd3, v); chk("R10 addr3 reads zero", v, 8'h00);
        host_read(2'd0, v); chk("R10 mode unchanged", v, 8'h05);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(5);
        rst_n = 1'b1;
        idle_cycles(5);
        t_reset();
        t_mode_rw();
        t_disabled_start();
        t_single();
        t_sequential();
        t_stop_armed();
        t_enable_clear();
        t_addr_map();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule